// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block holds the current word address of a 16K x 8 byte-wide memory that is split into 256 pages of 64 bytes. A serial protocol front end loads it from two received address bytes and then pulses a step strobe once for each data byte that has been fully transferred, including its acknowledge bit. The value persists between transactions. A later read that supplies no address therefore continues at the byte after the last one touched.

A mode input picks the stepping rule. In write mode the low six in-page bits count and wrap inside the current page, while the eight page bits stay fixed. In read mode the whole 14-bit address counts and wraps from the top of the array to zero. The memory array and the bus state machine are outside this block.

Top module: `wordaddr_cursor`

## Requirements
- R1: After reset the address output is 0.
- R2: A pulse on `ld_hi_i` writes `ld_byte_i[5:0]` into address bits [13:8] one clock later. Bits [7:6] of that byte are dropped. If `ld_lo_i` is low, address bits [7:0] are kept.
- R3: A pulse on `ld_lo_i` writes `ld_byte_i[7:0]` into address bits [7:0] one clock later. If `ld_hi_i` is low, bits [13:8] are kept.
- R4: With `rd_mode_i` = 0 (write), a `step_i` pulse adds one to address bits [5:0] modulo 64 and keeps bits [13:6]. Offset 63 of a page is followed by offset 0 of the same page.
- R5: With `rd_mode_i` = 1 (read), a `step_i` pulse adds one to the full 14-bit address modulo 16384. Address 16383 is followed by 0.
- R6: When either load strobe is high in the same cycle as `step_i`, the load is applied and the step is discarded in both modes.
- R7: With no strobe high, the address holds its value whatever `rd_mode_i` and `ld_byte_i` do.
- R8: Strobing `ld_hi_i` and `ld_lo_i` in the same cycle loads both fields from the one byte: bits [13:8] take byte[5:0] and bits [7:0] take byte[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_hi_i | input | 1 | Load strobe for the upper (page-side) address byte |
| ld_lo_i | input | 1 | Load strobe for the lower address byte |
| ld_byte_i | input | 8 | Received address byte |
| step_i | input | 1 | One pulse per completed data byte |
| rd_mode_i | input | 1 | Stepping rule: 0 = write (in-page wrap), 1 = read (whole-array wrap) |
| addr_o | output | 14 | Current word address |

## Verification
Loading and stepping can coincide. This happens when the front end strobes an address byte in the same cycle as a completed-data pulse. The bench raises `step_i` together with each load strobe, alone and in pairs, under both modes. It starts from addresses where a step would visibly change the result, such as offset 63 and the last array address. It then judges that the next address equals the loaded value with no increment applied.

// File: rtl/wordaddr_cursor_pkg.sv
package wordaddr_cursor_pkg;

    typedef enum logic {
        WALK_WR = 1'b0,
        WALK_RD = 1'b1
    } walk_mode_e;

endpackage

// File: rtl/wordaddr_load_merge.sv
module wordaddr_load_merge #(
    parameter int ADDR_W = 14,
    parameter int BYTE_W = 8,
    localparam int HI_W  = ADDR_W - BYTE_W
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              hi_stb_i,
    input  logic              lo_stb_i,
    input  logic [HI_W-1:0]   hi_part_i,
    input  logic [BYTE_W-1:0] lo_part_i,
    output logic              load_o,
    output logic [ADDR_W-1:0] merged_o
);
    always_comb begin
        merged_o = cur_i;
        if (hi_stb_i) begin
            merged_o[ADDR_W-1:BYTE_W] = hi_part_i;
        end
        if (lo_stb_i) begin
            merged_o[BYTE_W-1:0] = lo_part_i;
        end
        load_o = hi_stb_i | lo_stb_i;
    end
endmodule

// File: rtl/wordaddr_step.sv
module wordaddr_step
    import wordaddr_cursor_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int PAGE_BITS = 6
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  walk_mode_e        mode_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W-1:0]    linear;
    logic [ADDR_W-1:0]    paged;
    logic [PAGE_BITS-1:0] offs_inc;

    always_comb begin
        linear   = cur_i + ADDR_W'(1);
        offs_inc = cur_i[PAGE_BITS-1:0] + PAGE_BITS'(1);
        paged    = {cur_i[ADDR_W-1:PAGE_BITS], offs_inc};
        next_o   = (mode_i == WALK_RD) ? linear : paged;
    end
endmodule

// File: rtl/wordaddr_cursor.sv
module wordaddr_cursor
    import wordaddr_cursor_pkg::*;
#(
    parameter int PAGE_BITS = 6,
    parameter int ROW_BITS  = 8,
    parameter int BYTE_W    = 8,
    localparam int ADDR_W   = PAGE_BITS + ROW_BITS,
    localparam int HI_W     = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic [BYTE_W-1:0] ld_byte_i,
    input  logic              step_i,
    input  logic              rd_mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } cursor_t;

    cursor_t           st_d, st_q;
    logic              load_hit;
    logic [ADDR_W-1:0] loaded_addr;
    logic [ADDR_W-1:0] stepped_addr;
    walk_mode_e        mode;

    assign mode = walk_mode_e'(rd_mode_i);

    wordaddr_load_merge #(
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
    ) u_merge (
        .cur_i    (st_q.addr),
        .hi_stb_i (ld_hi_i),
        .lo_stb_i (ld_lo_i),
        .hi_part_i(ld_byte_i[HI_W-1:0]),
        .lo_part_i(ld_byte_i),
        .load_o   (load_hit),
        .merged_o (loaded_addr)
    );

    wordaddr_step #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_step (
        .cur_i (st_q.addr),
        .mode_i(mode),
        .next_o(stepped_addr)
    );

    always_comb begin
        st_d = st_q;
        if (load_hit) begin
            st_d.addr = loaded_addr;
        end else if (step_i) begin
            st_d.addr = stepped_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
endmodule

// File: rtl/wordaddr_cursor_chk.sv
module wordaddr_cursor_chk #(
    parameter int ADDR_W    = 14,
    parameter int PAGE_BITS = 6,
    parameter int BYTE_W    = 8,
    localparam int HI_W     = ADDR_W - BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_hi_i,
    input logic              ld_lo_i,
    input logic [BYTE_W-1:0] ld_byte_i,
    input logic              step_i,
    input logic              rd_mode_i,
    input logic [ADDR_W-1:0] addr_o
);
    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (rst_seen && rst_n) begin
            assert_reset_zero_R1: assert (addr_o == '0);
        end
    end

    assert_hi_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi_i |=> addr_o[ADDR_W-1:BYTE_W] == $past(ld_byte_i[HI_W-1:0]));

    assert_hi_keeps_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi_i && !ld_lo_i) |=> $stable(addr_o[BYTE_W-1:0]));

    assert_lo_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo_i |=> addr_o[BYTE_W-1:0] == $past(ld_byte_i));

    assert_lo_keeps_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo_i && !ld_hi_i) |=> $stable(addr_o[ADDR_W-1:BYTE_W]));

    assert_write_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_hi_i && !ld_lo_i && !rd_mode_i) |=>
        ($stable(addr_o[ADDR_W-1:PAGE_BITS]) &&
         addr_o[PAGE_BITS-1:0] == $past(addr_o[PAGE_BITS-1:0]) + PAGE_BITS'(1)));

    assert_read_linear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_hi_i && !ld_lo_i && rd_mode_i) |=>
        addr_o == $past(addr_o) + ADDR_W'(1));

    assert_load_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ld_hi_i && !ld_lo_i) |=> $stable(addr_o[BYTE_W-1:0]));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ld_hi_i && !ld_lo_i) |=> $stable(addr_o));
endmodule

bind wordaddr_cursor wordaddr_cursor_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .BYTE_W   (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_hi_i  (ld_hi_i),
    .ld_lo_i  (ld_lo_i),
    .ld_byte_i(ld_byte_i),
    .step_i   (step_i),
    .rd_mode_i(rd_mode_i),
    .addr_o   (addr_o)
);

// File: tb/sim_wordaddr_cursor.sv
module sim_wordaddr_cursor;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 14;
    localparam int SPAN       = 1 << AW;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_hi_i = 1'b0;
    logic          ld_lo_i = 1'b0;
    logic [7:0]    ld_byte_i = 8'h00;
    logic          step_i = 1'b0;
    logic          rd_mode_i = 1'b0;
    logic [AW-1:0] addr_o;

    int n_checks = 0;
    int n_errors = 0;
    int exp_addr = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wordaddr_cursor u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_hi_i  (ld_hi_i),
        .ld_lo_i  (ld_lo_i),
        .ld_byte_i(ld_byte_i),
        .step_i   (step_i),
        .rd_mode_i(rd_mode_i),
        .addr_o   (addr_o)
    );

    task automatic check(input string req, input int expv);
        n_checks++;
        if (int'(addr_o) != expv) begin
            n_errors++;
            $display("FAIL %s: addr=%0d expected=%0d", req, addr_o, expv);
        end
    endtask

    // One cycle: apply inputs at negedge, update the model, check after the edge.
    task automatic cyc(input bit hi, input bit lo, input logic [7:0] b,
                       input bit st, input bit rd, input string req, input bit do_chk);
        ld_hi_i = hi; ld_lo_i = lo; ld_byte_i = b; step_i = st; rd_mode_i = rd;
        if (hi || lo) begin
            if (hi) exp_addr = (exp_addr & 255) | (int'(b & 8'h3F) << 8);
            if (lo) exp_addr = (exp_addr & ~255) | int'(b);
        end else if (st) begin
            if (rd) exp_addr = (exp_addr + 1) % SPAN;
            else    exp_addr = (exp_addr & ~63) | ((exp_addr + 1) & 63);
        end
        @(posedge clk);
        #1;
        ld_hi_i = 1'b0; ld_lo_i = 1'b0; step_i = 1'b0;
        if (do_chk) check(req, exp_addr);
        @(negedge clk);
    endtask

    task automatic load_addr(input int a);
        cyc(1'b1, 1'b0, 8'((a >> 8) & 63), 1'b0, 1'b0, "R2", 1'b1);
        cyc(1'b0, 1'b1, 8'(a & 255), 1'b0, 1'b0, "R3", 1'b1);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
                $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1: reset value
        exp_addr = 0;
        check("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 0);

        // R2: upper bits of the high byte are dropped, low byte kept
        cyc(1'b0, 1'b1, 8'hA7, 1'b0, 1'b0, "R3", 1'b1);
        cyc(1'b1, 1'b0, 8'hC5, 1'b0, 1'b0, "R2", 1'b1);
        cyc(1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, "R2", 1'b1);
        // R3: low byte leaves high field
        cyc(1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, "R3", 1'b1);

        // R8: both strobes together
        cyc(1'b1, 1'b1, 8'h9B, 1'b0, 1'b0, "R8", 1'b1);
        cyc(1'b1, 1'b1, 8'h40, 1'b0, 1'b1, "R8", 1'b1);

        // R7: no strobes, mode and byte wiggle
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 1'b0, 8'(i * 37), 1'b0, 1'(i), "R7", 1'b1);
        end

        // R4: every page, start at offset 61 and cross the page edge
        for (int p = 0; p < 256; p++) begin
            load_addr(p * 64 + 61);
            for (int k = 0; k < 4; k++) begin
                cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R4", 1'b1);
            end
        end
        // R4: a full 70-step lap of one page
        load_addr(37 * 64 + 5);
        for (int k = 0; k < 70; k++) begin
            cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R4", 1'b1);
        end

        // R5: linear walk over page edges of every page, and top-of-array wrap
        for (int p = 0; p < 256; p++) begin
            load_addr(p * 64 + 62);
            for (int k = 0; k < 3; k++) begin
                cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5", 1'b1);
            end
        end
        load_addr(SPAN - 3);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5", 1'b1);
        end

        // R6: load together with step, both modes, all strobe combinations
        for (int m = 0; m < 2; m++) begin
            load_addr(SPAN - 1);
            cyc(1'b0, 1'b1, 8'hFF, 1'b1, 1'(m), "R6", 1'b1);
            cyc(1'b1, 1'b0, 8'h3F, 1'b1, 1'(m), "R6", 1'b1);
            cyc(1'b1, 1'b1, 8'h7F, 1'b1, 1'(m), "R6", 1'b1);
            load_addr(5 * 64 + 63);
            cyc(1'b0, 1'b1, 8'h7F, 1'b1, 1'(m), "R6", 1'b1);
        end

        // R7: value persists across idle time, then a read continues from it
        load_addr(200 * 64 + 10);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R4", 1'b1);
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b0, 8'hEE, 1'b0, 1'b1, "R7", 1'b1);
        end
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5", 1'b1);

        // R1: reset in mid-flight clears the address
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_addr = 0;
        check("R1", 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule